// File: doc/BRIEF.md
# Serial Clock Prescaler with Divide-by-16 Stage

This block derives the serial clock for a serial peripheral sequencer from the system clock. The division ratio is a fixed divide-by-4 multiplied by (prescale + 1), where prescale is a 4-bit field. An optional divide-by-16 stage multiplies the ratio by a further 16. The output rate can therefore be set anywhere from the system clock divided by 4 down to the system clock divided by 1024.

For each serial clock half-period the block emits a one-cycle toggle tick. It drives a serial clock level that rests at the configured idle level. It also marks each edge as a leading edge (moving away from idle) or a trailing edge (moving back to idle). The phase setting maps those edges onto sample and shift strobes.

A frame begins with a start pulse. The start pulse captures the configuration and restarts the divider. A stop pulse halts the clock and returns it to idle.

Top module: `sck_prescaler`

## Requirements
- R1: After reset all outputs are 0 and no tick appears until a start pulse is seen.
- R2: With cfg_div16_i = 0, a tick occurs every 2*(cfg_pm_i+1) system clocks, giving a serial clock period of 4*(cfg_pm_i+1) system clocks.
- R3: With cfg_div16_i = 1, a tick occurs every 32*(cfg_pm_i+1) system clocks, giving a serial clock period of 64*(cfg_pm_i+1) system clocks.
- R4: start_i restarts the divider even in the middle of a frame. The first tick appears exactly one half-period after the clock edge that samples start_i, and the output in the cycle right after that edge carries no tick.
- R5: sclk_o rests at cfg_idle_high_i (1 = idle high). It is set to that level by the edge that samples start_i, and it toggles on every tick.
- R6: The odd-numbered ticks of a frame (1st, 3rd, ...) drive sclk_o away from idle and assert lead_o. The even-numbered ticks drive it back to idle and assert trail_o.
- R7: With cfg_phase_i = 0, sample_o equals lead_o and shift_o equals trail_o. With cfg_phase_i = 1 the two roles are swapped.
- R8: The four cfg_* inputs are captured only when start_i is sampled. Changes to them during a frame have no effect until the next start.
- R9: stop_i halts the clock. In the cycle after the edge that samples it, sclk_o is at the captured idle level. No ticks appear until the next start. If start_i and stop_i are high together, start_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_pm_i | input | 4 | Prescale value PM; the ratio is multiplied by PM+1 |
| cfg_div16_i | input | 1 | Enables the extra divide-by-16 stage |
| cfg_idle_high_i | input | 1 | Idle level of the serial clock |
| cfg_phase_i | input | 1 | Selects which edge samples and which edge shifts |
| start_i | input | 1 | Frame start pulse: captures cfg and restarts the divider |
| stop_i | input | 1 | Frame end pulse: halts the clock at idle |
| sclk_o | output | 1 | Serial clock level |
| tick_o | output | 1 | One-cycle pulse on each serial clock toggle |
| lead_o | output | 1 | Tick that moves sclk_o away from idle |
| trail_o | output | 1 | Tick that returns sclk_o to idle |
| sample_o | output | 1 | Edge on which data is sampled |
| shift_o | output | 1 | Edge on which data is shifted |

## Verification
The assertions check the following on every cycle:
- the captured configuration holds between start pulses;
- no tick appears in the cycle after a start;
- the clock sits at idle while halted or after a stop;
- each tick flips the level;
- lead and trail ticks leave the level on the correct side of idle;
- the divider counters stay within their limits.

Only the bench's sweeps can show the exact tick spacing for every prescale value, with and without the divide-by-16 stage. The same applies to the sample/shift mapping under both phases and to the fact that configuration changes during a frame are ignored.

// File: rtl/sck_pkg.sv
package sck_pkg;
  localparam int unsigned PM_W_DEF   = 4;
  localparam int unsigned BASE_DIV_D = 2;   // half of the fixed /4
  localparam int unsigned EXT_DIV_D  = 16;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_e;
endpackage

// File: rtl/sck_mod_cnt.sv
module sck_mod_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && !clr_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= wrap_o ? '0 : cnt_q + W'(1);
  end

  // R2/R3: counter never passes its terminal value
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen
  import sck_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic idle_i,
  input  logic phase_i,
  output logic sclk_o,
  output logic tick_o,
  output logic lead_o,
  output logic trail_o,
  output logic sample_o,
  output logic shift_o
);
  logic  level_q;
  logic  tick_q;
  edge_e edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      tick_q  <= 1'b0;
      edge_q  <= EDGE_NONE;
    end else if (!run_i) begin
      level_q <= idle_i;
      tick_q  <= 1'b0;
      edge_q  <= EDGE_NONE;
    end else if (tick_i) begin
      level_q <= ~level_q;
      tick_q  <= 1'b1;
      edge_q  <= (level_q == idle_i) ? EDGE_LEAD : EDGE_TRAIL;
    end else begin
      tick_q  <= 1'b0;
      edge_q  <= EDGE_NONE;
    end
  end

  assign sclk_o   = level_q;
  assign tick_o   = tick_q;
  assign lead_o   = (edge_q == EDGE_LEAD);
  assign trail_o  = (edge_q == EDGE_TRAIL);
  assign sample_o = phase_i ? trail_o : lead_o;
  assign shift_o  = phase_i ? lead_o  : trail_o;

  // R5: every tick flips the clock level
  a_r5_tick_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (level_q != $past(level_q)));
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import sck_pkg::*;
#(
  parameter int unsigned PM_W     = PM_W_DEF,
  parameter int unsigned BASE_DIV = BASE_DIV_D,
  parameter int unsigned EXT_DIV  = EXT_DIV_D
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PM_W-1:0] cfg_pm_i,
  input  logic            cfg_div16_i,
  input  logic            cfg_idle_high_i,
  input  logic            cfg_phase_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic            sclk_o,
  output logic            tick_o,
  output logic            lead_o,
  output logic            trail_o,
  output logic            sample_o,
  output logic            shift_o
);
  localparam int unsigned BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned EXT_W  = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);
  localparam logic [EXT_W-1:0]  EXT_LAST  = EXT_W'(EXT_DIV - 1);

  logic            active_q;
  logic [PM_W-1:0] pm_q;
  logic            div16_q, idle_q, phase_q;
  logic            run_c, base_wrap, stage_en, tick_c, idle_sel;

  // frame control and config capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pm_q     <= '0;
      div16_q  <= 1'b0;
      idle_q   <= 1'b0;
      phase_q  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pm_q     <= cfg_pm_i;
      div16_q  <= cfg_div16_i;
      idle_q   <= cfg_idle_high_i;
      phase_q  <= cfg_phase_i;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end
  end

  assign run_c    = active_q && !start_i && !stop_i;
  assign idle_sel = start_i ? cfg_idle_high_i : idle_q;

  // fixed /2 half-period prescale (x2 per period gives /4)
  sck_mod_cnt #(.W(BASE_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run_c),
    .en_i   (run_c),
    .last_i (BASE_LAST),
    .wrap_o (base_wrap)
  );

  generate
    if (EXT_DIV > 1) begin : g_ext
      logic ext_wrap;
      sck_mod_cnt #(.W(EXT_W)) u_ext (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!run_c),
        .en_i   (base_wrap && div16_q),
        .last_i (EXT_LAST),
        .wrap_o (ext_wrap)
      );
      assign stage_en = div16_q ? ext_wrap : base_wrap;
    end else begin : g_no_ext
      assign stage_en = base_wrap;
    end
  endgenerate

  // (PM+1) stage
  sck_mod_cnt #(.W(PM_W)) u_pm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run_c),
    .en_i   (stage_en),
    .last_i (pm_q),
    .wrap_o (tick_c)
  );

  sck_edge_gen u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_c),
    .tick_i   (tick_c),
    .idle_i   (idle_sel),
    .phase_i  (phase_q),
    .sclk_o   (sclk_o),
    .tick_o   (tick_o),
    .lead_o   (lead_o),
    .trail_o  (trail_o),
    .sample_o (sample_o),
    .shift_o  (shift_o)
  );

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable({pm_q, div16_q, idle_q, phase_q}));

  a_r4_quiet_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!tick_o && sclk_o == idle_q));

  a_r9_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!tick_o && sclk_o == idle_q && !active_q));

  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!tick_o && sclk_o == idle_q));

  a_r6_lead_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != idle_q));

  a_r6_trail_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o == idle_q));

  a_r7_roles_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sample_o != shift_o));
endmodule

// File: tb/sck_prescaler_tb.sv
`timescale 1ns/1ps
module sck_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pm = '0;
  logic       d16 = 1'b0, idle = 1'b0, ph = 1'b0, start = 1'b0, stop = 1'b0;
  logic       sclk, tick, lead, trail, smp, shf;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sck_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pm_i(pm), .cfg_div16_i(d16),
    .cfg_idle_high_i(idle), .cfg_phase_i(ph), .start_i(start), .stop_i(stop),
    .sclk_o(sclk), .tick_o(tick), .lead_o(lead), .trail_o(trail),
    .sample_o(smp), .shift_o(shf)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Caller is at a negedge. Starts a frame, scrambles cfg inputs (R8), checks nhalf half-periods.
  task automatic run_frame(bit i_idle, bit i_ph, bit i_d16, int i_pm, int nhalf, bit with_stop);
    int h;
    string rq;
    h = 2 * (i_pm + 1) * (i_d16 ? 16 : 1);
    rq = i_d16 ? "R3" : "R2";
    pm = 4'(i_pm); d16 = i_d16; idle = i_idle; ph = i_ph;
    start = 1'b1; stop = with_stop;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    // R8: scrambled inputs during the frame must be ignored
    pm = ~4'(i_pm); d16 = ~i_d16; idle = ~i_idle; ph = ~i_ph;
    chk("R4", "tick after start", tick, 1'b0);
    chk("R5", "sclk after start", sclk, i_idle);
    for (int k = 1; k <= nhalf * h; k++) begin
      int  n;
      bit  et, el, etr;
      @(negedge clk);
      n   = k / h;
      et  = (k % h) == 0;
      el  = et && (n % 2 == 1);
      etr = et && (n % 2 == 0);
      chk(rq, "tick spacing (R8 cfg held)", tick, et);
      chk("R5", "sclk level", sclk, i_idle ^ n[0]);
      chk("R6", "lead", lead, el);
      chk("R6", "trail", trail, etr);
      chk("R7", "sample", smp, i_ph ? etr : el);
      chk("R7", "shift", shf, i_ph ? el : etr);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sclk in reset", sclk, 1'b0);
    chk("R1", "tick in reset", tick, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "no tick before start", tick, 1'b0);
    chk("R1", "lead before start", lead, 1'b0);
    chk("R1", "sclk before start", sclk, 1'b0);

    // R2/R5/R6/R7: all prescale values, all idle/phase combos; back-to-back starts exercise R4 restart
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 16; p++)
        run_frame(c[0], c[1], 1'b0, p, 3, 1'b0);
    // R3: divide-by-16 stage
    for (int p = 0; p < 16; p++)
      run_frame(p[0], p[1], 1'b1, p, 3, 1'b0);

    // R4: restart in the middle of a half-period
    run_frame(1'b0, 1'b0, 1'b0, 3, 1, 1'b0);
    repeat (3) @(negedge clk);
    run_frame(1'b1, 1'b1, 1'b0, 2, 3, 1'b0);

    // R9: stop mid-frame, clock parks at idle with no ticks
    run_frame(1'b1, 1'b0, 1'b0, 2, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9", "sclk away from idle before stop", sclk, 1'b0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9", "sclk idle after stop", sclk, 1'b1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R9", "no tick while stopped", tick, 1'b0);
      chk("R9", "sclk held idle", sclk, 1'b1);
    end
    // R9: start beats stop in the same cycle
    run_frame(1'b0, 1'b1, 1'b0, 1, 4, 1'b1);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule